// File: doc/BRIEF.md
# Software-Driven Two-Wire Line Register

This block lets software run a two-wire serial bus (clock line and data line, I2C style) by hand, one line transition per register write. It sits on a 32-bit APB-style register bus and decodes a 4 KB window. It has no data register that software loads directly. A "release" address raises latch bits and a "drive" address lowers them, so a driver can move one line without knowing the state of the other.

Each line is open-drain. A latch bit of 1 lets the line float high through the external pull-up. A latch bit of 0 enables the pad driver, which always drives zero. One read word reports the clock level that software has commanded next to the data level seen on the wire. The data level passes through a two-flop synchronizer first, so software can see an acknowledge or a read bit from the far end. Any access to an offset the block does not define completes at once with an error response.

Top module: `twowire_bitbang`

## Requirements
- R1: After reset the line latch is 2'b00: `scl_oe` and `sda_oe` are 1, `scl_o` and `sda_o` are 0, and a read of offset 0x000 returns 0 in bit 0.
- R2: A write to offset 0x000 ORs `pwdata[1:0]` into the latch. Bit 0 is the clock line and bit 1 is the data line, and 1 means released. `pwdata[31:2]` has no effect.
- R3: A write to offset 0x004 clears each latch bit whose `pwdata` bit is 1 and leaves the other bit unchanged.
- R4: Each pad enable is the inverse of its latch bit, and `scl_o`/`sda_o` are always 0. The pad enables change only as the result of a completed write.
- R5: A write changes the latch on the rising edge that completes the transfer. The pad enables follow on the next rising edge.
- R6: A read of offset 0x000 returns the clock latch bit in bit 0 and the synchronized data-line level in bit 1. Bits 31:2 are always 0.
- R7: A change on `sda_i` shows up in read bit 1 after exactly two rising edges.
- R8: `pslverr` is asserted in the access phase of any transfer whose 12-bit offset is not defined for its direction. This covers a read of 0x004, unaligned offsets and offsets above 0x004. An errored write leaves the latch unchanged.
- R9: An errored read returns all-zero `prdata`.
- R10: `pready` is always 1, so every transfer takes no wait states. A read has no side effect on the latch or the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response for undefined offsets |
| scl_oe | output | 1 | Clock pad driver enable (1 = pull low) |
| scl_o | output | 1 | Clock pad output value (always 0) |
| sda_oe | output | 1 | Data pad driver enable (1 = pull low) |
| sda_o | output | 1 | Data pad output value (always 0) |
| sda_i | input | 1 | Data line level sensed at the pad |

## Verification
`pslverr` and read data are combinational in the access phase, so the bench samples them just after it raises `penable`, before the completing edge. After a write completes, the bench first confirms that the pad enables still hold their old value. It then waits one more rising edge and compares them with its own latch model. For the synchronizer it holds a read open while it toggles `sda_i`, and checks read bit 1 before the first edge, after the first edge and after the second edge. The bit must change only at the last of those points.

// File: rtl/twb_pkg.sv
package twb_pkg;

    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int NUM_LINES = 2;

    typedef logic [NUM_LINES-1:0] lines_t;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_RELEASE = 2'd1,
        OP_DRIVE   = 2'd2,
        OP_READ    = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic err;
    } dec_t;

    // next latch state for a decoded operation
    function automatic lines_t latch_next(op_e op, lines_t cur, lines_t mask);
        lines_t nxt;
        nxt = cur;
        case (op)
            OP_RELEASE: nxt = cur | mask;
            OP_DRIVE:   nxt = cur & ~mask;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    // an open-drain pad pulls low exactly when its line is not released
    function automatic lines_t pad_enables(lines_t released);
        return ~released;
    endfunction

endpackage

// File: rtl/twb_decode.sv
module twb_decode
    import twb_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] REL_OFS = 12'h000,
    parameter logic [11:0] DRV_OFS = 12'h004
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec
);

    logic access;
    logic hit_rel;
    logic hit_drv;

    assign access  = psel & penable;
    assign hit_rel = (paddr == ADDR_W'(REL_OFS));
    assign hit_drv = (paddr == ADDR_W'(DRV_OFS));

    always_comb begin
        dec.op  = OP_IDLE;
        dec.err = 1'b0;
        if (access) begin
            if (pwrite) begin
                if (hit_rel)      dec.op  = OP_RELEASE;
                else if (hit_drv) dec.op  = OP_DRIVE;
                else              dec.err = 1'b1;
            end else begin
                if (hit_rel) dec.op  = OP_READ;
                else         dec.err = 1'b1;
            end
        end
    end

endmodule

// File: rtl/twb_latch.sv
module twb_latch
    import twb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_e    op,
    input  lines_t mask,
    output lines_t lines_q
);

    always_ff @(posedge clk) begin
        if (rst) lines_q <= '0;
        else     lines_q <= latch_next(op, lines_q, mask);
    end

endmodule

// File: rtl/twb_sync.sv
module twb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/twb_pad.sv
module twb_pad
    import twb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t released,
    output lines_t oe,
    output lines_t o
);

    lines_t oe_d;
    assign oe_d = pad_enables(released);

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) oe[l] <= 1'b1;
                else     oe[l] <= oe_d[l];
            end
            assign o[l] = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/twowire_bitbang.sv
module twowire_bitbang
    import twb_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [11:0] REL_OFS     = 12'h000,
    parameter logic [11:0] DRV_OFS     = 12'h004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              scl_oe,
    output logic              scl_o,
    output logic              sda_oe,
    output logic              sda_o,
    input  logic              sda_i
);

    localparam int UPPER_W = DATA_W - NUM_LINES;

    dec_t   dec;
    lines_t lines_q;
    lines_t pad_oe;
    lines_t pad_o;
    logic   sda_seen;
    logic   unused_wdata_hi;

    assign unused_wdata_hi = ^pwdata[DATA_W-1:NUM_LINES];

    twb_decode #(
        .ADDR_W (ADDR_W),
        .REL_OFS(REL_OFS),
        .DRV_OFS(DRV_OFS)
    ) u_decode (
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .dec    (dec)
    );

    twb_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .op     (dec.op),
        .mask   (pwdata[NUM_LINES-1:0]),
        .lines_q(lines_q)
    );

    twb_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (sda_i),
        .q  (sda_seen)
    );

    twb_pad u_pad (
        .clk     (clk),
        .rst     (rst),
        .released(lines_q),
        .oe      (pad_oe),
        .o       (pad_o)
    );

    always_comb begin
        prdata = '0;
        if (dec.op == OP_READ) begin
            prdata[LINE_SCL] = lines_q[LINE_SCL];
            prdata[LINE_SDA] = sda_seen;
        end
    end

    assign pready  = 1'b1;
    assign pslverr = dec.err;
    assign scl_oe  = pad_oe[LINE_SCL];
    assign sda_oe  = pad_oe[LINE_SDA];
    assign scl_o   = pad_o[LINE_SCL];
    assign sda_o   = pad_o[LINE_SDA];

    if (UPPER_W < 1) begin : g_width_bad
        initial $error("DATA_W must exceed the line count");
    end

endmodule

// File: rtl/twb_chk.sv
module twb_chk #(
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 32,
    parameter logic [11:0] REL_OFS = 12'h000,
    parameter logic [11:0] DRV_OFS = 12'h004
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              sda_i
);

    logic [1:0] cyc;
    logic acc, wr_acc, rel_wr, drv_wr, rd_ok, good;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assign acc    = psel && penable;
    assign rel_wr = acc && pwrite && (paddr == ADDR_W'(REL_OFS));
    assign drv_wr = acc && pwrite && (paddr == ADDR_W'(DRV_OFS));
    assign rd_ok  = acc && !pwrite && (paddr == ADDR_W'(REL_OFS));
    assign good   = rel_wr || drv_wr || rd_ok;
    assign wr_acc = acc && pwrite;

    // R2
    rel_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_wr && pwdata[0]) |=> ##1 !scl_oe);
    // R2
    rel_sda_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_wr && pwdata[1]) |=> ##1 !sda_oe);
    // R3
    drv_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_wr && pwdata[0]) |=> ##1 scl_oe);
    // R3
    drv_sda_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_wr && pwdata[1]) |=> ##1 sda_oe);
    // R4
    pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && !$past(wr_acc) && !$past(wr_acc, 2))
        |-> ($stable(scl_oe) && $stable(sda_oe)));
    // R6
    rd_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && rd_ok && !$past(wr_acc)) |-> (prdata[0] == !scl_oe));
    // R6
    rd_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        prdata[DATA_W-1:2] == '0);
    // R7
    sda_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && rd_ok && $stable(sda_i) && ($past(sda_i) == $past(sda_i, 2)))
        |-> (prdata[1] == sda_i));
    // R8
    bad_ofs_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !good) |-> pslverr);
    // R8
    good_ofs_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc || good) |-> !pslverr);
    // R9
    err_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !pwrite && pslverr) |-> (prdata == '0));
    // R10
    no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        pready);

endmodule

bind twowire_bitbang twb_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REL_OFS(REL_OFS),
    .DRV_OFS(DRV_OFS)
) u_twb_chk (
    .clk    (clk),
    .rst    (rst),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .prdata (prdata),
    .pready (pready),
    .pslverr(pslverr),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .sda_i  (sda_i)
);

// File: tb/tb_twowire_bitbang.sv
`timescale 1ns/1ps
module tb_twowire_bitbang;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        scl_oe, scl_o, sda_oe, sda_o;
    logic        sda_i;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [1:0]  mdl;            // bench model of the latch: [0]=clock, [1]=data, 1=released

    always #4 clk = ~clk;        // 125 MHz

    twowire_bitbang dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .scl_oe(scl_oe), .scl_o(scl_o), .sda_oe(sda_oe),
        .sda_o(sda_o), .sda_i(sda_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // full transfer; returns the response sampled in the access phase
    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic err, output logic rdy);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr; rdy = pready;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // checks pads right after write completion (old) and one edge later (new)
    task automatic wr_check(input logic [11:0] a, input logic [31:0] d,
                            input logic [1:0] nxt, input string req);
        logic [31:0] rd; logic err, rdy;
        logic [1:0] prev;
        prev = mdl;
        xfer(1'b1, a, d, rd, err, rdy);
        chk(err == 1'b0, req, {31'd0, err}, 32'd0);
        // R5: pads still show the previous state after the completing edge
        chk({sda_oe, scl_oe} == ~prev, "R5", {30'd0, sda_oe, scl_oe}, {30'd0, ~prev});
        mdl = nxt;
        @(posedge clk); @(negedge clk);
        chk({sda_oe, scl_oe} == ~mdl, req, {30'd0, sda_oe, scl_oe}, {30'd0, ~mdl});
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic err, rdy;
        chk({scl_oe, sda_oe} == 2'b11, "R1", {30'd0, scl_oe, sda_oe}, 32'd3);
        chk({scl_o, sda_o} == 2'b00, "R1", {30'd0, scl_o, sda_o}, 32'd0);
        xfer(1'b0, 12'h000, 32'd0, rd, err, rdy);
        chk(rd == 32'h2, "R1", rd, 32'h2);
        chk(err == 1'b0 && rdy == 1'b1, "R10", {30'd0, err, rdy}, 32'd1);
    endtask

    task automatic t_release;
        logic [31:0] rd; logic err, rdy;
        // upper bits set must be ignored (R2); only clock bit released
        wr_check(12'h000, 32'hFFFF_FFFD, 2'b01, "R2");
        xfer(1'b0, 12'h000, 32'd0, rd, err, rdy);
        chk(rd == 32'h3, "R6", rd, 32'h3);
        wr_check(12'h000, 32'h0000_0002, 2'b11, "R2");
        chk({scl_o, sda_o} == 2'b00, "R4", {30'd0, scl_o, sda_o}, 32'd0);
    endtask

    task automatic t_drive;
        logic [31:0] rd; logic err, rdy;
        wr_check(12'h004, 32'h0000_0001, 2'b10, "R3");
        xfer(1'b0, 12'h000, 32'd0, rd, err, rdy);
        chk(rd == 32'h2, "R6", rd, 32'h2);
        wr_check(12'h004, 32'hFFFF_FFFE, 2'b00, "R3");
        wr_check(12'h000, 32'h0000_0003, 2'b11, "R2");
    endtask

    task automatic t_errors;
        logic [31:0] rd; logic err, rdy;
        xfer(1'b1, 12'h008, 32'h3, rd, err, rdy);
        chk(err == 1'b1, "R8", {31'd0, err}, 32'd1);
        xfer(1'b1, 12'h804, 32'h3, rd, err, rdy);
        chk(err == 1'b1, "R8", {31'd0, err}, 32'd1);
        xfer(1'b0, 12'h004, 32'd0, rd, err, rdy);
        chk(err == 1'b1, "R8", {31'd0, err}, 32'd1);
        chk(rd == 32'd0, "R9", rd, 32'd0);
        xfer(1'b0, 12'h001, 32'd0, rd, err, rdy);
        chk(err == 1'b1 && rd == 32'd0, "R9", rd, 32'd0);
        @(posedge clk); @(negedge clk);
        chk({sda_oe, scl_oe} == ~mdl, "R8", {30'd0, sda_oe, scl_oe}, {30'd0, ~mdl});
        xfer(1'b0, 12'h000, 32'd0, rd, err, rdy);
        chk(rd[0] == mdl[0], "R8", rd, {31'd0, mdl[0]});
    endtask

    task automatic t_sync;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
        @(negedge clk);
        penable = 1'b1;
        sda_i = 1'b0;
        #1 chk(prdata[1] == 1'b1, "R7", prdata, 32'h2);
        @(negedge clk);
        chk(prdata[1] == 1'b1, "R7", prdata, 32'h2);
        @(negedge clk);
        chk(prdata[1] == 1'b0, "R7", prdata, 32'h0);
        psel = 1'b0; penable = 1'b0;
        sda_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_read_quiet;
        logic [31:0] rd1, rd2; logic err, rdy;
        xfer(1'b0, 12'h000, 32'hFFFF_FFFF, rd1, err, rdy);
        xfer(1'b0, 12'h000, 32'hFFFF_FFFF, rd2, err, rdy);
        @(posedge clk); @(negedge clk);
        chk(rd1 == rd2 && rdy, "R10", rd2, rd1);
        chk({sda_oe, scl_oe} == ~mdl, "R10", {30'd0, sda_oe, scl_oe}, {30'd0, ~mdl});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; sda_i = 1'b1; mdl = 2'b00;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_release();
        t_drive();
        t_errors();
        t_sync();
        t_read_quiet();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule